// File: doc/BRIEF.md
# Store Byte-Lane Steering Unit

This block sits between a processor's store path and a data memory that is organised in 32-bit words and has one write strobe per byte lane. It takes a 2-bit store kind, a byte address and the store data. From these it produces four lane strobes, the outgoing write data, the word index for the memory, and a flag for misaligned stores.

The outgoing data copies the low halfword into both halves for halfword stores. For byte stores it copies the low byte into all four lanes. The memory then only needs to honour the strobes to update the right bytes. Lane placement is little-endian. The word index is taken from the address the same way for every store kind.

The unit is purely combinational. It has no clock and no reset, so its outputs settle within the cycle in which the inputs are presented.

Top module: `store_lane_steer`

## Requirements
- R1: Store kind 2'b00 means no store: all four lane strobes are 0 and the misalignment flag is 0.
- R2: For every store kind, the word index output equals address bits [31:2].
- R3: Store kind 2'b01 (word) with address bits [1:0] = 00 drives strobes 4'b1111 and passes the write data through unchanged.
- R4: Store kind 2'b10 (halfword) with address bit 0 = 0 drives strobes 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. The write data carries input bits [15:0] in both output bits [15:0] and [31:16].
- R5: Store kind 2'b11 (byte) drives exactly one strobe, bit k, where k is address bits [1:0]. Strobe bit k covers data bits [8k+7:8k]. The write data carries input bits [7:0] in all four byte lanes. A byte store never raises the misalignment flag.
- R6: The misalignment flag is 1 for a word store whose address bits [1:0] are not 00, or for a halfword store whose address bit 0 is 1. Whenever the flag is 1, all four strobes are 0.
- R7: Outputs follow a change of inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| st_kind_i | input | 2 | Store kind: 00 none, 01 word, 10 halfword, 11 byte |
| addr_i | input | 32 | Byte address of the store |
| wdata_i | input | 32 | Store data, with narrow stores right-aligned |
| lane_we_o | output | 4 | Per-lane write strobe, bit k covers data bits [8k+7:8k] |
| wdata_o | output | 32 | Lane-steered write data |
| word_idx_o | output | 30 | Word index for the memory |
| misalign_o | output | 1 | Misaligned word or halfword store |

## Verification
Every store kind is applied at all four address offsets. This separates correct lane selection from shifted or swapped lane mappings, and separates the misaligned offsets from the aligned ones.

Each combination is repeated with three kinds of data: distinct bytes per lane, all ones, and pseudo-random words. A steering error that copies the wrong byte or halfword would look correct with uniform data, so distinct-per-lane data is what shows it up.

Pseudo-random upper address bits show whether the word index tracks the address independently of the store kind. Inputs change with no clock edge between stimulus and sampling, which confirms that nothing in the path is registered.

// File: rtl/store_lane_steer_pkg.sv
// Package: shared store-kind encoding for the store lane steering unit.
// Assumes a 2-bit store kind supplied by the processor's control decode.
package store_lane_steer_pkg;

    typedef enum logic [1:0] {
        ST_NONE = 2'b00,
        ST_WORD = 2'b01,
        ST_HALF = 2'b10,
        ST_BYTE = 2'b11
    } st_kind_e;

endpackage

// File: rtl/lane_strobe_dec.sv
// Module: lane_strobe_dec
// Turns a store kind and the in-word byte offset into per-lane strobes and a
// misalignment flag. Assumes an even lane count and little-endian lanes.
// A misaligned word or halfword store suppresses every strobe.
module lane_strobe_dec
    import store_lane_steer_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFS_W = $clog2(LANES)
) (
    input  st_kind_e             kind,
    input  logic [OFS_W-1:0]     ofs,
    output logic [LANES-1:0]     lane_we,
    output logic                 misalign
);

    logic [LANES-1:0] raw_we;

    // Purpose: flag word stores off a word boundary and halfword stores off a halfword boundary.
    always_comb begin
        unique case (kind)
            ST_WORD: misalign = (ofs != '0);
            ST_HALF: misalign = ofs[0];
            default: misalign = 1'b0;
        endcase
    end

    // One strobe per lane, chosen by the store kind and the byte offset.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Purpose: decide whether lane i is written for this store kind.
        always_comb begin
            unique case (kind)
                ST_WORD: raw_we[i] = 1'b1;
                ST_HALF: raw_we[i] = (ofs[OFS_W-1:1] == (OFS_W-1)'(i / 2));
                ST_BYTE: raw_we[i] = (ofs == OFS_W'(i));
                default: raw_we[i] = 1'b0;
            endcase
        end
    end

    // Purpose: a misaligned store writes nothing.
    always_comb begin
        lane_we = misalign ? '0 : raw_we;
    end

endmodule

// File: rtl/lane_data_steer.sv
// Module: lane_data_steer
// Replicates the narrow store operand across the lanes so that the strobes alone
// pick the bytes that change. Assumes narrow data is right-aligned at the input.
module lane_data_steer
    import store_lane_steer_pkg::*;
#(
    parameter int LANES = 4,
    localparam int DATA_W = LANES * 8
) (
    input  st_kind_e            kind,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W-1:0]   dout
);

    // One output byte per lane, taken from the input byte the store kind maps there.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Purpose: pick the source byte for lane i.
        always_comb begin
            unique case (kind)
                ST_HALF: dout[i*8 +: 8] = din[(i % 2)*8 +: 8];
                ST_BYTE: dout[i*8 +: 8] = din[7:0];
                default: dout[i*8 +: 8] = din[i*8 +: 8];
            endcase
        end
    end

endmodule

// File: rtl/store_lane_steer.sv
// Module: store_lane_steer (top)
// Combinational store-side steering between the datapath and a word-wide
// memory with byte strobes. No clock and no reset: outputs track inputs.
// Assumes a 2-bit store kind encoded as in store_lane_steer_pkg.
module store_lane_steer
    import store_lane_steer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES  = 4,
    localparam int DATA_W = LANES * 8,
    localparam int OFS_W  = $clog2(LANES),
    localparam int IDX_W  = ADDR_W - OFS_W
) (
    input  logic [1:0]        st_kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [LANES-1:0]  lane_we_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [IDX_W-1:0]  word_idx_o,
    output logic              misalign_o
);

    st_kind_e kind;

    // Purpose: give the raw store-kind code its enumerated type.
    always_comb begin
        kind = st_kind_e'(st_kind_i);
    end

    // Purpose: the memory is word-addressed for every store kind.
    always_comb begin
        word_idx_o = addr_i[ADDR_W-1:OFS_W];
    end

    lane_strobe_dec #(.LANES(LANES)) u_dec (
        .kind     (kind),
        .ofs      (addr_i[OFS_W-1:0]),
        .lane_we  (lane_we_o),
        .misalign (misalign_o)
    );

    lane_data_steer #(.LANES(LANES)) u_steer (
        .kind (kind),
        .din  (wdata_i),
        .dout (wdata_o)
    );

endmodule

// File: rtl/store_lane_steer_chk.sv
// Module: store_lane_steer_chk
// Checker bound to store_lane_steer. The block has no clock, so the checks are
// immediate assertions evaluated whenever the ports change.
module store_lane_steer_chk (
    input logic [1:0]  st_kind_i,
    input logic [31:0] addr_i,
    input logic [31:0] wdata_i,
    input logic [3:0]  lane_we_o,
    input logic [31:0] wdata_o,
    input logic [29:0] word_idx_o,
    input logic        misalign_o
);

    // Purpose: relate outputs to inputs for every store kind.
    always_comb begin
        if (st_kind_i == 2'b00) begin
            p_idle_quiet_r1: assert (lane_we_o == 4'b0000 && !misalign_o);
        end
        p_word_index_r2: assert (word_idx_o == addr_i[31:2]);
        if (st_kind_i == 2'b01 && addr_i[1:0] == 2'b00) begin
            p_word_all_lanes_r3: assert (lane_we_o == 4'b1111 && wdata_o == wdata_i);
        end
        if (st_kind_i == 2'b10 && !addr_i[0]) begin
            p_half_pair_r4: assert ($countones(lane_we_o) == 2
                && wdata_o[15:0] == wdata_i[15:0] && wdata_o[31:16] == wdata_i[15:0]);
        end
        if (st_kind_i == 2'b11) begin
            p_byte_single_r5: assert ($countones(lane_we_o) == 1 && !misalign_o
                && wdata_o == {4{wdata_i[7:0]}});
        end
        if (misalign_o) begin
            p_misalign_quiet_r6: assert (lane_we_o == 4'b0000);
        end
    end

endmodule

bind store_lane_steer store_lane_steer_chk u_chk (.*);

// File: tb/store_lane_steer_tb.sv
// Bench for store_lane_steer: a behavioural model compared every clock period.
module store_lane_steer_tb;

    logic        clk = 1'b0;
    logic [1:0]  st_kind_i = 2'b00;
    logic [31:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [3:0]  lane_we_o;
    logic [31:0] wdata_o;
    logic [29:0] word_idx_o;
    logic        misalign_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #4 clk = ~clk;  // 125 MHz

    store_lane_steer u_dut (
        .st_kind_i  (st_kind_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .lane_we_o  (lane_we_o),
        .wdata_o    (wdata_o),
        .word_idx_o (word_idx_o),
        .misalign_o (misalign_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    // Apply one store and compare against the behavioural model.
    task automatic apply(input logic [1:0] kind, input logic [31:0] addr, input logic [31:0] data);
        int ofs;
        logic [3:0]  e_we;
        logic [31:0] e_data;
        logic        e_mis;
        string tag;
        @(negedge clk);
        st_kind_i = kind;
        addr_i = addr;
        wdata_i = data;
        #1;  // R7: settles with no clock edge in between
        ofs = int'(addr[1:0]);
        e_we = 4'b0000;
        e_data = data;
        e_mis = 1'b0;
        case (kind)
            2'b00: tag = "R1";
            2'b01: begin
                tag = (ofs == 0) ? "R3" : "R6";
                e_mis = (ofs != 0);
                if (!e_mis) e_we = 4'b1111;
            end
            2'b10: begin
                tag = (ofs % 2 == 0) ? "R4" : "R6";
                e_mis = (ofs % 2 == 1);
                if (!e_mis) e_we = (ofs >= 2) ? 4'b1100 : 4'b0011;
                e_data = {data[15:0], data[15:0]};
            end
            default: begin
                tag = "R5";
                e_we = 4'(1 << ofs);
                e_data = {data[7:0], data[7:0], data[7:0], data[7:0]};
            end
        endcase
        check({tag, " strobes"}, {28'b0, lane_we_o}, {28'b0, e_we});
        check({tag, " misalign"}, {31'b0, misalign_o}, {31'b0, e_mis});
        if (e_we != 4'b0000) check({tag, " data R7"}, wdata_o, e_data);
        check("R2 word index", {2'b0, word_idx_o}, {2'b0, addr[31:2]});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] pats[3];
        pats[0] = 32'hA1B2_C3D4;
        pats[1] = 32'hFFFF_FFFF;
        // reset-state view: no store kind applied yet, R1
        apply(2'b00, 32'h0, 32'h0);
        for (int p = 0; p < 3; p++) begin
            if (p == 2) pats[2] = lfsr;
            for (int k = 0; k < 4; k++) begin
                for (int o = 0; o < 4; o++) begin
                    lfsr = next_rand(lfsr);
                    apply(2'(k), {lfsr[31:2], 2'(o)}, pats[p]);
                end
            end
        end
        for (int n = 0; n < 200; n++) begin
            logic [31:0] a;
            lfsr = next_rand(lfsr);
            a = lfsr;
            lfsr = next_rand(lfsr);
            apply(a[5:4], a, lfsr);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule